// File: doc/BRIEF.md
# Wakeup capture controller

This block watches a bank of interrupt request lines while the main interrupt controller is powered off, and keeps a sticky record of every request that qualifies, so that power control can wake the system and software can later find out which lines fired. Every line has three settings of its own: a mask bit, a polarity bit that chooses active-high/rising or active-low/falling, and a sensitivity bit that chooses edge or level detection. Lines are grouped 32 to a register word.

Software reaches the block through a simple single-cycle register bus. Each setting is changed only through a write-one-to-set word and a write-one-to-clear word, so one line can be changed without a read-modify-write. The captured bits are read from a status word and cleared by writing ones to an acknowledge word. A control word holds a global capture enable and a self-clearing soft reset that wipes every captured bit. A single wakeup output is high while any unmasked line holds a captured bit.

Top module: `wic_top`

## Requirements
- R1: Line n lives in word n/32 at bit n%32. The byte address is {group[11:8], action[7:6], word[5:2], 2'b00}, and the port bus_addr carries byte-address bits [11:2]. Groups: 0 control, 1 mask, 2 polarity, 3 sensitivity, 4 status. Actions: 0 read view, 1 write-one-to-set, 2 write-one-to-clear. Writes to the read view of the mask, polarity and sensitivity groups are ignored.
- R2: A 1 written to a bit of the mask set word masks that line, and a 1 written to the mask clear word unmasks it. Bits written as 0 keep their value.
- R3: The polarity set action selects positive detection (rising edge or high level) and the clear action selects negative detection (falling edge or low level). Transitions the other way are not captured.
- R4: Sensitivity 0 means edge and 1 means level, with set and clear actions. Writing 1 to the clear action forces the line back to edge mode.
- R5: After reset all mask bits are 1, all polarity bits are 0, all sensitivity bits are 0, all status bits are 0, the control word reads 0 and wake_out is 0.
- R6: The control word at word 0 has the capture enable at bit 0. While it is 0, no status bit is set.
- R7: In edge mode a status bit is set on the clock edge where the polarity-adjusted input is seen to turn active. Once acknowledged, it stays clear while the input stays active.
- R8: In level mode a status bit is set whenever the adjusted input is active, and it is set again right after an acknowledge while the input is still active.
- R9: Writing 1 to a bit of the status clear action (acknowledge) clears that captured bit. Bits written as 0 keep their value.
- R10: Writing 1 to control bit 1 clears every status bit one cycle after the write, and the bit then clears itself. Bit 1 always reads as 0, and the enable written in the same word is kept.
- R11: A masked line never sets its status bit. wake_out is the OR over all lines of status AND NOT mask, so masking a line that already holds a captured bit drops its share of wake_out without clearing the status.
- R12: When an acknowledge and a new qualifying event reach the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 10 | Byte address bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_in | input | NUM_LINES (64) | Raw interrupt lines, synchronous to clk |
| wake_out | output | 1 | High while any unmasked line holds a captured bit |

## Verification
The assertions check on every cycle that a masked or disabled line never gains a status bit, that an acknowledge clears its bits unless a new event arrives in the same cycle, that the soft reset empties the status and drops itself, and that wake_out never rises while the status is empty. Only the bench's scenarios can show the detection itself: polarity choice, a single capture per edge compared with re-capture in level mode, the word and bit placement of each line, the set and clear semantics of each settings word, and the reset values seen through the bus.

// File: rtl/wic_pkg.sv
package wic_pkg;

  localparam int WORD_W = 32;
  localparam int WIDX_W = 4;   // word index field in the bus address

  typedef enum logic [3:0] {
    RG_CTRL  = 4'd0,
    RG_MASK  = 4'd1,
    RG_POL   = 4'd2,
    RG_SENSE = 4'd3,
    RG_STAT  = 4'd4
  } group_e;

  typedef enum logic [1:0] {
    ACT_VIEW = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } action_e;

  // bus_addr carries byte address bits [11:2]
  typedef struct packed {
    logic [3:0]        group;
    logic [1:0]        action;
    logic [WIDX_W-1:0] word;
  } reg_sel_t;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 1;

  // new value of a settings word after a set and/or clear strobe
  function automatic logic [WORD_W-1:0] set_clear(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] set_bits,
    input logic [WORD_W-1:0] clr_bits
  );
    return (cur | set_bits) & ~clr_bits;
  endfunction

  // raw input turned into "active = 1" according to polarity
  function automatic logic polarize(input logic raw, input logic positive);
    return positive ? raw : ~raw;
  endfunction

  // level mode: active now; edge mode: active now and idle last cycle
  function automatic logic qualifies(input logic adj, input logic prev, input logic level);
    return level ? adj : (adj & ~prev);
  endfunction

endpackage

// File: rtl/wic_field.sv
module wic_field
  import wic_pkg::*;
#(
  parameter int   NUM_WORDS = 2,
  parameter logic RST_BIT   = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_we,
  input  logic                        clr_we,
  input  logic [WIDX_W-1:0]           word,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NUM_WORDS*WORD_W-1:0] q
);

  logic [WORD_W-1:0] set_bits, clr_bits;
  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              sel_w;
    assign sel_w = (word == WIDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= {WORD_W{RST_BIT}};
      else if (sel_w) word_q <= set_clear(word_q, set_bits, clr_bits);
    end

    assign q[w*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/wic_capture.sv
module wic_capture
  import wic_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] mask_q,
  input  logic [NUM_LINES-1:0] pol_q,
  input  logic [NUM_LINES-1:0] sense_q,
  input  logic                 en_q,
  input  logic                 srst_q,
  input  logic                 ack_we,
  input  logic [WIDX_W-1:0]    word,
  input  logic [WORD_W-1:0]    wdata,
  output logic [NUM_LINES-1:0] hit_vec,
  output logic [NUM_LINES-1:0] ack_vec,
  output logic [NUM_LINES-1:0] stat_q
);

  logic [NUM_LINES-1:0] adj, prev_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign adj[i]     = polarize(irq_in[i], pol_q[i]);
    assign hit_vec[i] = en_q & ~mask_q[i] & qualifies(adj[i], prev_q[i], sense_q[i]);
    assign ack_vec[i] = ack_we & (word == WIDX_W'(i / WORD_W)) & wdata[i % WORD_W];
  end

  // history follows the input even when masked or disabled, so that
  // enabling never turns a stale level into an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= adj;
      stat_q <= srst_q ? '0 : ((stat_q & ~ack_vec) | hit_vec);
    end
  end

endmodule

// File: rtl/wic_top.sv
module wic_top
  import wic_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [9:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 wake_out
);

  localparam int NUM_WORDS = NUM_LINES / WORD_W;

  reg_sel_t sel;
  assign sel = reg_sel_t'(bus_addr);

  function automatic logic wr_hit(input reg_sel_t s, input group_e g, input action_e a);
    return (s.group == g) && (s.action == a);
  endfunction

  function automatic logic [WORD_W-1:0] pick(input logic [NUM_LINES-1:0] v,
                                             input logic [WIDX_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (w == WIDX_W'(k)) r = v[k*WORD_W +: WORD_W];
    return r;
  endfunction

  // named write strobes
  logic mask_set_we, mask_clr_we, pol_set_we, pol_clr_we;
  logic sense_set_we, sense_clr_we, ack_we, ctrl_wr, srst_wr;

  assign mask_set_we  = bus_we && wr_hit(sel, RG_MASK,  ACT_SET);
  assign mask_clr_we  = bus_we && wr_hit(sel, RG_MASK,  ACT_CLR);
  assign pol_set_we   = bus_we && wr_hit(sel, RG_POL,   ACT_SET);
  assign pol_clr_we   = bus_we && wr_hit(sel, RG_POL,   ACT_CLR);
  assign sense_set_we = bus_we && wr_hit(sel, RG_SENSE, ACT_SET);
  assign sense_clr_we = bus_we && wr_hit(sel, RG_SENSE, ACT_CLR);
  assign ack_we       = bus_we && wr_hit(sel, RG_STAT,  ACT_CLR);
  assign ctrl_wr      = bus_we && wr_hit(sel, RG_CTRL,  ACT_VIEW) && (sel.word == '0);
  assign srst_wr      = ctrl_wr && bus_wdata[CTRL_SRST_BIT];

  // control word
  logic en_q, srst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= bus_wdata[CTRL_EN_BIT];
      srst_q <= srst_wr;
    end
  end

  // per-line settings
  logic [NUM_LINES-1:0] mask_q, pol_q, sense_q;

  wic_field #(.NUM_WORDS(NUM_WORDS), .RST_BIT(1'b1)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(mask_set_we), .clr_we(mask_clr_we),
    .word(sel.word), .wdata(bus_wdata), .q(mask_q));

  wic_field #(.NUM_WORDS(NUM_WORDS), .RST_BIT(1'b0)) u_pol (
    .clk(clk), .rst_n(rst_n), .set_we(pol_set_we), .clr_we(pol_clr_we),
    .word(sel.word), .wdata(bus_wdata), .q(pol_q));

  wic_field #(.NUM_WORDS(NUM_WORDS), .RST_BIT(1'b0)) u_sense (
    .clk(clk), .rst_n(rst_n), .set_we(sense_set_we), .clr_we(sense_clr_we),
    .word(sel.word), .wdata(bus_wdata), .q(sense_q));

  // detection and sticky status
  logic [NUM_LINES-1:0] hit_vec, ack_vec, stat_q;

  wic_capture #(.NUM_LINES(NUM_LINES)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mask_q(mask_q), .pol_q(pol_q), .sense_q(sense_q),
    .en_q(en_q), .srst_q(srst_q), .ack_we(ack_we),
    .word(sel.word), .wdata(bus_wdata),
    .hit_vec(hit_vec), .ack_vec(ack_vec), .stat_q(stat_q));

  assign wake_out = |(stat_q & ~mask_q);

  // read path, same cycle
  always_comb begin
    bus_rdata = '0;
    if (sel.action == ACT_VIEW) begin
      case (group_e'(sel.group))
        RG_CTRL:  if (sel.word == '0) bus_rdata = {{(WORD_W-1){1'b0}}, en_q};
        RG_MASK:  bus_rdata = pick(mask_q,  sel.word);
        RG_POL:   bus_rdata = pick(pol_q,   sel.word);
        RG_SENSE: bus_rdata = pick(sense_q, sel.word);
        RG_STAT:  bus_rdata = pick(stat_q,  sel.word);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] stat_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] hit_vec,
  input logic [NUM_LINES-1:0] ack_vec,
  input logic                 en_q,
  input logic                 srst_q,
  input logic                 srst_wr,
  input logic                 wake_out
);

  a_r11_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  a_r6_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> ((stat_q & ~$past(stat_q)) == '0));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(ack_vec) & ~$past(hit_vec)) == '0));

  a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_q |=> (($past(hit_vec) & ~stat_q) == '0));

  a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (stat_q == '0));

  a_r10_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_wr |=> !srst_q);

  a_r11_wake_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> (stat_q != '0));

endmodule

bind wic_top wic_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .mask_q(mask_q),
  .hit_vec(hit_vec), .ack_vec(ack_vec), .en_q(en_q), .srst_q(srst_q),
  .srst_wr(srst_wr), .wake_out(wake_out));

// File: tb/sim_wic_top.sv
`timescale 1ns/1ps
module sim_wic_top;

  localparam int LINES = 64;
  // group and action codes as given in the requirements (R1)
  localparam int G_CTRL = 0, G_MASK = 1, G_POL = 2, G_SENSE = 3, G_STAT = 4;
  localparam int A_VIEW = 0, A_SET = 1, A_CLR = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_we = 1'b0;
  logic [9:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [LINES-1:0] irq_in = '0;
  logic             wake_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  wic_top #(.NUM_LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .wake_out(wake_out));

  function automatic logic [9:0] ra(input int g, input int a, input int w);
    return 10'((g << 6) | (a << 4) | w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wake_chk(input string req, input logic exp);
    #1;
    chk(req, {31'b0, wake_out}, {31'b0, exp});
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
  endtask

  task automatic t_reset;
    rd_chk("R5 ctrl",     ra(G_CTRL, A_VIEW, 0), 32'h0);
    rd_chk("R5 mask w0",  ra(G_MASK, A_VIEW, 0), 32'hFFFF_FFFF);
    rd_chk("R5 mask w1",  ra(G_MASK, A_VIEW, 1), 32'hFFFF_FFFF);
    rd_chk("R5 pol w0",   ra(G_POL, A_VIEW, 0), 32'h0);
    rd_chk("R5 sense w1", ra(G_SENSE, A_VIEW, 1), 32'h0);
    rd_chk("R5 stat w0",  ra(G_STAT, A_VIEW, 0), 32'h0);
    wake_chk("R5 wake", 1'b0);
  endtask

  task automatic t_mask_ops;
    wr(ra(G_MASK, A_CLR, 0), 32'h5);
    rd_chk("R2 clear bits",   ra(G_MASK, A_VIEW, 0), 32'hFFFF_FFFA);
    wr(ra(G_MASK, A_SET, 0), 32'h0);
    wr(ra(G_MASK, A_CLR, 0), 32'h0);
    rd_chk("R2 zeros keep",   ra(G_MASK, A_VIEW, 0), 32'hFFFF_FFFA);
    wr(ra(G_MASK, A_SET, 0), 32'h1);
    rd_chk("R2 set bit",      ra(G_MASK, A_VIEW, 0), 32'hFFFF_FFFB);
    wr(ra(G_MASK, A_VIEW, 0), 32'h0);
    rd_chk("R1 view write ignored", ra(G_MASK, A_VIEW, 0), 32'hFFFF_FFFB);
    wr(ra(G_MASK, A_SET, 0), 32'h4);
    rd_chk("R2 restore",      ra(G_MASK, A_VIEW, 0), 32'hFFFF_FFFF);
  endtask

  task automatic t_edge;
    wr(ra(G_MASK, A_CLR, 0), 32'h8);
    wr(ra(G_POL, A_SET, 0), 32'h8);
    rd_chk("R3 pol set", ra(G_POL, A_VIEW, 0), 32'h8);
    line(3, 1'b1);
    rd_chk("R6 disabled", ra(G_STAT, A_VIEW, 0), 32'h0);
    line(3, 1'b0);
    wr(ra(G_CTRL, A_VIEW, 0), 32'h1);
    rd_chk("R6 enable reads", ra(G_CTRL, A_VIEW, 0), 32'h1);
    line(3, 1'b1);
    rd_chk("R7 rising captured", ra(G_STAT, A_VIEW, 0), 32'h8);
    wake_chk("R11 wake on", 1'b1);
    wr(ra(G_STAT, A_CLR, 0), 32'h8);
    rd_chk("R7 R9 ack held high", ra(G_STAT, A_VIEW, 0), 32'h0);
    wake_chk("R11 wake off", 1'b0);
    line(3, 1'b0);
    rd_chk("R3 falling ignored", ra(G_STAT, A_VIEW, 0), 32'h0);
    // negative polarity on line 4
    wr(ra(G_MASK, A_CLR, 0), 32'h10);
    line(4, 1'b1);
    rd_chk("R3 neg ignores rise", ra(G_STAT, A_VIEW, 0), 32'h0);
    line(4, 1'b0);
    rd_chk("R3 neg falling", ra(G_STAT, A_VIEW, 0), 32'h10);
    wr(ra(G_STAT, A_CLR, 0), 32'h10);
    wr(ra(G_MASK, A_SET, 0), 32'h10);
    // line 33 -> word 1 bit 1
    wr(ra(G_MASK, A_CLR, 1), 32'h2);
    wr(ra(G_POL, A_SET, 1), 32'h2);
    line(33, 1'b1);
    rd_chk("R1 line33 word1", ra(G_STAT, A_VIEW, 1), 32'h2);
    rd_chk("R1 line33 not word0", ra(G_STAT, A_VIEW, 0), 32'h0);
    line(33, 1'b0);
    wr(ra(G_STAT, A_CLR, 1), 32'h2);
    rd_chk("R9 ack word1", ra(G_STAT, A_VIEW, 1), 32'h0);
  endtask

  task automatic t_level;
    wr(ra(G_MASK, A_CLR, 1), 32'h100);
    wr(ra(G_POL, A_SET, 1), 32'h100);
    wr(ra(G_SENSE, A_SET, 1), 32'h100);
    rd_chk("R4 sense set", ra(G_SENSE, A_VIEW, 1), 32'h100);
    line(40, 1'b1);
    rd_chk("R8 level captured", ra(G_STAT, A_VIEW, 1), 32'h100);
    wr(ra(G_STAT, A_CLR, 1), 32'h100);
    rd_chk("R8 relatch after ack", ra(G_STAT, A_VIEW, 1), 32'h100);
    line(40, 1'b0);
    wr(ra(G_STAT, A_CLR, 1), 32'h100);
    rd_chk("R8 clear when idle", ra(G_STAT, A_VIEW, 1), 32'h0);
    wr(ra(G_SENSE, A_CLR, 1), 32'h100);
    rd_chk("R4 sense clear", ra(G_SENSE, A_VIEW, 1), 32'h0);
    wr(ra(G_MASK, A_SET, 1), 32'h100);
  endtask

  task automatic t_masked;
    line(5, 1'b1);
    line(5, 1'b0);
    rd_chk("R11 masked no capture", ra(G_STAT, A_VIEW, 0), 32'h0);
    wake_chk("R11 masked no wake", 1'b0);
    line(3, 1'b1);
    line(3, 1'b0);
    wr(ra(G_MASK, A_SET, 0), 32'h8);
    rd_chk("R11 status kept", ra(G_STAT, A_VIEW, 0), 32'h8);
    wake_chk("R11 wake gated", 1'b0);
    wr(ra(G_MASK, A_CLR, 0), 32'h8);
    wake_chk("R11 wake back", 1'b1);
    wr(ra(G_STAT, A_CLR, 0), 32'h8);
  endtask

  task automatic t_race;
    line(3, 1'b1);
    line(3, 1'b0);
    rd_chk("R12 precondition", ra(G_STAT, A_VIEW, 0), 32'h8);
    @(negedge clk);
    irq_in[3] = 1'b1;
    bus_we = 1'b1; bus_addr = ra(G_STAT, A_CLR, 0); bus_wdata = 32'h8;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    rd_chk("R12 event beats ack", ra(G_STAT, A_VIEW, 0), 32'h8);
    line(3, 1'b0);
    wr(ra(G_STAT, A_CLR, 0), 32'h8);
    rd_chk("R9 plain ack", ra(G_STAT, A_VIEW, 0), 32'h0);
  endtask

  task automatic t_srst;
    wr(ra(G_MASK, A_CLR, 1), 32'h2);
    line(3, 1'b1);
    line(33, 1'b1);
    rd_chk("R10 pre w0", ra(G_STAT, A_VIEW, 0), 32'h8);
    rd_chk("R10 pre w1", ra(G_STAT, A_VIEW, 1), 32'h2);
    wr(ra(G_CTRL, A_VIEW, 0), 32'h3);
    @(negedge clk);
    rd_chk("R10 cleared w0", ra(G_STAT, A_VIEW, 0), 32'h0);
    rd_chk("R10 cleared w1", ra(G_STAT, A_VIEW, 1), 32'h0);
    rd_chk("R10 bit reads 0", ra(G_CTRL, A_VIEW, 0), 32'h1);
    wake_chk("R10 wake low", 1'b0);
    line(3, 1'b0);
    line(3, 1'b1);
    rd_chk("R10 capture resumes", ra(G_STAT, A_VIEW, 0), 32'h8);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_mask_ops();
    t_edge();
    t_level();
    t_masked();
    t_race();
    t_srst();
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule